// File: doc/BRIEF.md
# Programmable Fill Threshold Unit

This block sits beside a FIFO core. It holds two threshold offsets, one measured up from empty and one measured down from full, and turns the core's fill count into two active-low warning flags: an almost-empty flag in the read clock domain and an almost-full flag in the write clock domain. Both flags are registered and recomputed on every edge of their own clock.

The offsets come from one of two programming methods. The method is fixed at master reset by the level of the shared load-select pin. Load-select low selects the parallel method with small defaults. Load-select high selects the serial method with large defaults. In the parallel method, write-side loads take an offset from the low bits of the data bus. In the serial method, each enabled write edge shifts in one bit. On the read side, the offsets can be read back in parallel whichever method is in force. Parallel loads and readbacks each alternate between the two offsets, and always begin with the empty offset.

A partial reset moves both alternation sequences back to the empty offset. It leaves the offsets and the programming method unchanged.

Top module: `ofs_thresh_unit`

## Requirements
- R1: With master reset low and load-select low, both offsets become DEF_SMALL (127) and the parallel method is selected.
- R2: With master reset low and load-select high, both offsets become DEF_LARGE (1023) and the serial method is selected.
- R3: In the parallel method, a write edge with write enable low and load-select low stores dIn[ADDR_W-1:0]. Successive loads go to the empty offset first, then the full offset, alternating. Write enable low with load-select high changes no offset.
- R4: In the serial method, parallel load strobes change no offset.
- R5: In the serial method, a write edge with serial enable low and load-select low shifts one bit through a 2*ADDR_W-bit chain. After 2*ADDR_W shifts, the first bit sent is the LSB of the empty offset and the last bit sent is the MSB of the full offset.
- R6: In the parallel method, serial shift strobes change no offset.
- R7: A read edge with read enable low and load-select low drives qOut one cycle later with an offset in bits [ADDR_W-1:0] and zeros above. It alternates empty then full and works in either method. Otherwise qOut holds.
- R8: On each read edge out of master reset, paeN becomes 0 when fill <= emptyOffset, else 1.
- R9: On each write edge out of master reset, pafN becomes 0 when (2^ADDR_W - fill) <= fullOffset, else 1.
- R10: Partial reset keeps both offsets and the method, ignores load and read strobes while low, and returns both alternation sequences to the empty offset.
- R11: During master reset, paeN is 0, pafN is 1 and qOut is 0 from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| mrstN | input | 1 | Master reset, active low, synchronous |
| prstN | input | 1 | Partial reset, active low, synchronous |
| ldN | input | 1 | Load-select, active low; picks the method during master reset |
| wenN | input | 1 | Write enable, active low |
| senN | input | 1 | Serial enable, active low |
| serIn | input | 1 | Serial offset bit |
| dIn | input | DATA_W | Parallel data in |
| renN | input | 1 | Read enable, active low |
| fill | input | ADDR_W+1 | Fill count from the FIFO core, 0 to 2^ADDR_W |
| qOut | output | DATA_W | Offset readback data |
| paeN | output | 1 | Almost-empty flag, active low |
| pafN | output | 1 | Almost-full flag, active low |

## Verification
The bench sweeps the fill count across each threshold edge: the offset value and one step past it. An off-by-one comparison would move a flag edge by one entry. It checks that the alternation sequence restarts after a partial reset taken midway through a pair. A design that kept its pointer would put the next load into the full offset. It drives the strobes of the method that is not selected, and then reads both offsets back unchanged; a design that decodes the wrong method would corrupt them. It also shifts a known pattern bit by bit, so that a reversed shift direction or swapped halves shows up as wrong readback values.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  // write-domain strobes from control to datapath
  typedef struct packed {
    logic mstInit;   // master reset in progress
    logic defLarge;  // pick the large default
    logic parLoad;   // parallel offset load
    logic serShift;  // serial shift by one bit
    logic toFull;    // parallel target is the full offset
  } wrStrobeT;

  // read-domain strobes from control to datapath
  typedef struct packed {
    logic mstInit;
    logic readOut;   // drive an offset onto qOut
    logic fromFull;  // readback source is the full offset
  } rdStrobeT;
endpackage

// File: rtl/ofs_ctrl.sv
module ofs_ctrl
  import ofs_pkg::*;
(
  input  logic     wrClk,
  input  logic     rdClk,
  input  logic     mrstN,
  input  logic     prstN,
  input  logic     ldN,
  input  logic     wenN,
  input  logic     senN,
  input  logic     renN,
  output wrStrobeT wrStb,
  output rdStrobeT rdStb
);
  logic serMode;
  logic wrSel;
  logic rdSel;
  logic opOk;

  assign opOk = mrstN && prstN;

  // method latched from load-select while master reset is low
  always_ff @(posedge wrClk) begin
    if (!mrstN) serMode <= ldN;
  end

  always_comb begin
    wrStb.mstInit  = !mrstN;
    wrStb.defLarge = ldN;
    wrStb.parLoad  = opOk && !serMode && !wenN && !ldN;
    wrStb.serShift = opOk &&  serMode && !senN && !ldN;
    wrStb.toFull   = wrSel;
  end

  always_ff @(posedge wrClk) begin
    if (!mrstN || !prstN) wrSel <= 1'b0;
    else if (wrStb.parLoad) wrSel <= !wrSel;
  end

  always_comb begin
    rdStb.mstInit  = !mrstN;
    rdStb.readOut  = opOk && !renN && !ldN;
    rdStb.fromFull = rdSel;
  end

  always_ff @(posedge rdClk) begin
    if (!mrstN || !prstN) rdSel <= 1'b0;
    else if (rdStb.readOut) rdSel <= !rdSel;
  end
endmodule

// File: rtl/ofs_datapath.sv
module ofs_datapath
  import ofs_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 18,
  parameter int DEF_SMALL = 127,
  parameter int DEF_LARGE = 1023
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  wrStrobeT          wrStb,
  input  rdStrobeT          rdStb,
  input  logic              serIn,
  input  logic [DATA_W-1:0] dIn,
  input  logic [ADDR_W:0]   fill,
  output logic [DATA_W-1:0] qOut,
  output logic              paeN,
  output logic              pafN
);
  localparam int CHAIN_W = 2 * ADDR_W;
  localparam logic [ADDR_W:0]   DEPTH_V = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W-1:0] DEF_S   = ADDR_W'(DEF_SMALL);
  localparam logic [ADDR_W-1:0] DEF_L   = ADDR_W'(DEF_LARGE);

  // {fullOff, emptyOff}; serial bits enter at the top and move down
  logic [CHAIN_W-1:0] ofsPair;
  logic [ADDR_W-1:0]  emptyOff;
  logic [ADDR_W-1:0]  fullOff;
  logic [ADDR_W-1:0]  defVal;
  logic [ADDR_W-1:0]  rdSrc;
  logic [DATA_W-1:0]  rdWord;
  logic [ADDR_W:0]    freeCnt;

  assign emptyOff = ofsPair[ADDR_W-1:0];
  assign fullOff  = ofsPair[CHAIN_W-1:ADDR_W];
  assign defVal   = wrStb.defLarge ? DEF_L : DEF_S;

  always_ff @(posedge wrClk) begin
    if (wrStb.mstInit) begin
      ofsPair <= {defVal, defVal};
    end else if (wrStb.parLoad) begin
      if (wrStb.toFull) ofsPair[CHAIN_W-1:ADDR_W] <= dIn[ADDR_W-1:0];
      else              ofsPair[ADDR_W-1:0]       <= dIn[ADDR_W-1:0];
    end else if (wrStb.serShift) begin
      ofsPair <= {serIn, ofsPair[CHAIN_W-1:1]};
    end
  end

  assign rdSrc = rdStb.fromFull ? fullOff : emptyOff;

  generate
    if (DATA_W > ADDR_W) begin : g_pad
      assign rdWord = {{(DATA_W-ADDR_W){1'b0}}, rdSrc};
    end else begin : g_trim
      assign rdWord = rdSrc[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge rdClk) begin
    if (rdStb.mstInit) qOut <= '0;
    else if (rdStb.readOut) qOut <= rdWord;
  end

  always_ff @(posedge rdClk) begin
    if (rdStb.mstInit) paeN <= 1'b0;
    else paeN <= !(fill <= {1'b0, emptyOff});
  end

  assign freeCnt = DEPTH_V - fill;

  always_ff @(posedge wrClk) begin
    if (wrStb.mstInit) pafN <= 1'b1;
    else pafN <= !(freeCnt <= {1'b0, fullOff});
  end
endmodule

// File: rtl/ofs_thresh_unit.sv
module ofs_thresh_unit
  import ofs_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 18,
  parameter int DEF_SMALL = 127,
  parameter int DEF_LARGE = 1023
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              prstN,
  input  logic              ldN,
  input  logic              wenN,
  input  logic              senN,
  input  logic              serIn,
  input  logic [DATA_W-1:0] dIn,
  input  logic              renN,
  input  logic [ADDR_W:0]   fill,
  output logic [DATA_W-1:0] qOut,
  output logic              paeN,
  output logic              pafN
);
  wrStrobeT wrStb;
  rdStrobeT rdStb;

  ofs_ctrl u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .ldN(ldN), .wenN(wenN), .senN(senN), .renN(renN),
    .wrStb(wrStb), .rdStb(rdStb)
  );

  ofs_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DEF_SMALL(DEF_SMALL), .DEF_LARGE(DEF_LARGE)
  ) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .wrStb(wrStb), .rdStb(rdStb),
    .serIn(serIn), .dIn(dIn), .fill(fill),
    .qOut(qOut), .paeN(paeN), .pafN(pafN)
  );
endmodule

// File: rtl/ofs_thresh_chk.sv
module ofs_thresh_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 18
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              mrstN,
  input logic              prstN,
  input logic              ldN,
  input logic              renN,
  input logic [ADDR_W:0]   fill,
  input logic [DATA_W-1:0] qOut,
  input logic              paeN,
  input logic              pafN
);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(1) << ADDR_W;

  p_rst_rd_r11: assert property (@(posedge rdClk)
    !mrstN |=> (!paeN && qOut == '0));
  p_rst_wr_r11: assert property (@(posedge wrClk)
    !mrstN |=> pafN);
  p_hold_r7: assert property (@(posedge rdClk) disable iff (!mrstN)
    (mrstN && (renN || ldN || !prstN)) |=> $stable(qOut));
  p_pae_at_empty_r8: assert property (@(posedge rdClk) disable iff (!mrstN)
    (mrstN && fill == '0) |=> !paeN);
  p_pae_at_full_r8: assert property (@(posedge rdClk) disable iff (!mrstN)
    (mrstN && fill == DEPTH_V) |=> paeN);
  p_paf_at_full_r9: assert property (@(posedge wrClk) disable iff (!mrstN)
    (mrstN && fill == DEPTH_V) |=> !pafN);
  p_paf_at_empty_r9: assert property (@(posedge wrClk) disable iff (!mrstN)
    (mrstN && fill == '0) |=> pafN);
endmodule

bind ofs_thresh_unit ofs_thresh_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN), .ldN(ldN),
  .renN(renN), .fill(fill), .qOut(qOut), .paeN(paeN), .pafN(pafN)
);

// File: tb/ofs_thresh_unit_test.sv
`timescale 1ns/1ps
module ofs_thresh_unit_test;
  localparam int AW = 12;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;
  localparam int MASK = DEPTH - 1;

  logic clk = 1'b0;
  logic wrClk, rdClk;
  logic mrstN = 1'b0, prstN = 1'b1, ldN = 1'b0, wenN = 1'b1, senN = 1'b1;
  logic serIn = 1'b0, renN = 1'b1;
  logic [DW-1:0] dIn = '0;
  logic [AW:0] fill = '0;
  logic [DW-1:0] qOut;
  logic paeN, pafN;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // behavioural reference state
  int mE = 0, mF = 0, mW = 0, mR = 0, mQ = 0;
  bit mSer = 0, mPae = 0, mPaf = 1;

  always #2.5 clk = ~clk;
  assign wrClk = clk;
  assign rdClk = clk;

  ofs_thresh_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN), .ldN(ldN),
    .wenN(wenN), .senN(senN), .serIn(serIn), .dIn(dIn), .renN(renN),
    .fill(fill), .qOut(qOut), .paeN(paeN), .pafN(pafN)
  );

  always @(posedge clk) begin
    int f;
    bit nPae, nPaf;
    longint chain;
    f = int'(fill);
    if (!mrstN) begin
      mE = ldN ? 1023 : 127; mF = mE; mSer = ldN;
      mW = 0; mR = 0; mQ = 0; mPae = 0; mPaf = 1;
    end else begin
      nPae = (f <= mE) ? 1'b0 : 1'b1;
      nPaf = ((DEPTH - f) <= mF) ? 1'b0 : 1'b1;
      if (!prstN) begin
        mW = 0; mR = 0;
      end else begin
        if (!renN && !ldN) begin
          mQ = (mR != 0) ? mF : mE;
          mR = 1 - mR;
        end
        if (!mSer && !wenN && !ldN) begin
          if (mW != 0) mF = int'(dIn) & MASK; else mE = int'(dIn) & MASK;
          mW = 1 - mW;
        end else if (mSer && !senN && !ldN) begin
          chain = longint'(mF) * DEPTH + mE;
          chain = (chain >> 1) + (longint'(serIn) << (2*AW-1));
          mE = int'(chain % DEPTH);
          mF = int'(chain / DEPTH);
        end
      end
      mPae = nPae; mPaf = nPaf;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // advance one clock, compare with the model at the falling edge
  task automatic tick();
    @(negedge clk);
    chk(paeN == mPae, "R8", paeN, mPae);
    chk(pafN == mPaf, "R9", pafN, mPaf);
    chk(int'(qOut) == mQ, "R7", int'(qOut), mQ);
  endtask

  task automatic rb(input int exp, input string req);
    renN = 0; ldN = 0;
    tick();
    chk(int'(qOut) == exp, req, int'(qOut), exp);
    renN = 1; ldN = 1;
  endtask

  task automatic pload(input int v);
    wenN = 0; ldN = 0; dIn = DW'(v);
    tick();
    wenN = 1; ldN = 1;
  endtask

  task automatic sload(input int e, input int f);
    for (int i = 0; i < 2*AW; i++) begin
      senN = 0; ldN = 0;
      serIn = (i < AW) ? e[i] : f[i-AW];
      tick();
    end
    senN = 1; ldN = 1;
  endtask

  task automatic flag(input int f, input bit expPae, input bit expPaf, input string req);
    fill = (AW+1)'(f);
    tick();
    if (req == "R8") chk(paeN == expPae, "R8", paeN, expPae);
    else chk(pafN == expPaf, "R9", pafN, expPaf);
  endtask

  task automatic mreset(input bit ld);
    mrstN = 0; ldN = ld;
    tick(); tick();
    chk(paeN == 0, "R11", paeN, 0);
    chk(pafN == 1, "R11", pafN, 1);
    chk(qOut == '0, "R11", int'(qOut), 0);
    mrstN = 1; ldN = 1;
    tick();
  endtask

  initial begin
    // R1: parallel method, small defaults
    mreset(1'b0);
    rb(127, "R1");
    rb(127, "R1");
    // R3: parallel loads alternate empty then full
    pload(300);
    pload(3900);
    rb(300, "R3");
    rb(3900, "R3");
    // write enable with load-select high: no offset change (R3)
    wenN = 0; ldN = 1; dIn = 18'd55; tick(); tick(); wenN = 1;
    rb(300, "R3");
    rb(3900, "R3");
    // R8/R9 threshold edges
    flag(300, 0, 0, "R8");
    flag(301, 1, 0, "R8");
    flag(196, 0, 0, "R9");
    flag(195, 0, 1, "R9");
    // R6: serial strobes ignored in parallel method
    sload(MASK, MASK);
    rb(300, "R6");
    rb(3900, "R6");
    // R10: partial reset keeps offsets, restarts the sequence
    pload(50);
    prstN = 0; tick(); tick(); prstN = 1;
    pload(60);
    rb(60, "R10");
    rb(3900, "R10");
    rb(60, "R10");
    prstN = 0; tick(); prstN = 1;
    rb(60, "R10");
    // R2: serial method, large defaults
    mreset(1'b1);
    rb(1023, "R2");
    rb(1023, "R2");
    // R4: parallel loads ignored in serial method
    pload(11);
    pload(22);
    rb(1023, "R4");
    rb(1023, "R4");
    // R5: serial load LSB first, empty then full
    sload(5, 4000);
    rb(5, "R5");
    rb(4000, "R5");
    // R7: readback still works after a partial reset in serial method (R10)
    prstN = 0; tick(); prstN = 1;
    rb(5, "R10");
    flag(5, 0, 0, "R8");
    flag(6, 1, 0, "R8");
    flag(96, 0, 0, "R9");
    flag(95, 0, 1, "R9");
    flag(0, 0, 1, "R8");
    flag(DEPTH, 1, 0, "R9");
    // mixed stimulus against the model
    for (int n = 0; n < 4000; n++) begin
      fill = (AW+1)'($urandom_range(0, DEPTH));
      ldN = ($urandom_range(0, 2) == 0);
      ldN = !ldN;
      wenN = $urandom_range(0, 1);
      senN = $urandom_range(0, 1);
      renN = $urandom_range(0, 1);
      serIn = $urandom_range(0, 1);
      dIn = DW'($urandom());
      prstN = ($urandom_range(0, 40) != 0);
      mrstN = ($urandom_range(0, 300) != 0);
      tick();
    end
    mrstN = 1; prstN = 1; ldN = 1; wenN = 1; senN = 1; renN = 1;
    tick();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule